// File: doc/BRIEF.md
# Debug Watchpoint Comparator Unit

This block watches a processor's memory bus and decides when the core should stop and enter debug state. It holds a small bank of comparator units, two by default. Each unit compares the live address, data and control values with a value register and a mask register for each of the three fields, and drives its own hit pin while the bus matches. A control register sets how each unit's hit is used. A unit can stop the core on an instruction fetch or on a data access, and it can require its own external condition input to be high before the hit counts. A breakpoint input and an external debug request give two more ways to stop the core.

Every request is held pending until the core reports that the current instruction has completed. Only then does the acknowledge output rise, and it stays high until the debugger releases the core. A status register keeps the causes of the last debug entry. A global enable input turns off every request source. A one-word mailbox in each direction lets the debugger and the core exchange data, and each direction has an empty flag. Software reaches all state through a synchronous write port and a combinational read port.

Top module: `dbg_watch_unit`

## Requirements
- R1: After reset all value, mask, control and status registers read 0, every hit pin is low, acknowledge and internal request are low, and both mailbox empty flags are high.
- R2: A unit's hit pin is high exactly when bus_valid is high, the unit's enable bit is set, and for each of address, data and control every bit whose mask bit is 0 equals the value bit (mask bit 1 = don't care).
- R3: A unit triggers when its hit is high and its mode bit selects the current access type (0 = fetch, bus_fetch=1; 1 = data, bus_fetch=0), and, if its qualify bit is set, its ext_cond bit is high.
- R4: bkpt_in raises a request only in a cycle where bus_valid is high.
- R5: ext_dbg_req raises dbg_req_int in the same cycle and leaves a request pending after the next clock edge.
- R6: A trigger seen at a clock edge sets a pending request, which shows on dbg_req_int from then on. dbg_ack rises at the first edge where a request is pending and instr_done is high. It stays high until an edge with dbg_exit high.
- R7: While dbg_en is low, dbg_req_int is low, no request is pending, and dbg_ack is low from the next edge.
- R8: On debug entry, status bit u records a trigger from unit u and bit N_UNITS records bkpt_in or ext_dbg_req, summed over the pending period. Status is read at register address 8*N_UNITS+1, and writes to it are ignored.
- R9: A write to address 8*N_UNITS+2 fills the core-to-debugger word (tx_empty falls) only when it is empty. tx_pop empties it again.
- R10: rx_push fills the debugger-to-core word (rx_empty falls) only when it is empty. A read with reg_re at address 8*N_UNITS+3 returns it and empties it.
- R11: Unit u's registers sit at 8*u+f (f: 0 addr value, 1 addr mask, 2 data value, 3 data mask, 4 ctrl value, 5 ctrl mask). Control is at 8*N_UNITS, with bits [N-1:0] enable, [2N-1:N] mode and [3N-1:2N] qualify. Each register reads back truncated to its field width.
- R12: While dbg_ack is high, triggers, bkpt_in and ext_dbg_req leave no pending request after exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | A bus access is present |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_addr | input | ADDR_W | Access address |
| bus_data | input | DATA_W | Access data |
| bus_ctrl | input | CTRL_W | Access control attributes |
| ext_cond | input | N_UNITS | Per-unit external qualifying condition |
| bkpt_in | input | 1 | Marks the current access as breakpointed |
| ext_dbg_req | input | 1 | External debug request |
| instr_done | input | 1 | Current instruction has completed |
| dbg_exit | input | 1 | Leave debug state |
| dbg_en | input | 1 | Global debug enable |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (side effect on mailbox) |
| reg_addr | input | REG_AW | Register address |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data |
| rx_push | input | 1 | Debugger writes mailbox word to core |
| rx_data | input | REG_W | Word from debugger |
| tx_pop | input | 1 | Debugger takes the core's word |
| tx_data | output | REG_W | Word for the debugger |
| wp_hit | output | N_UNITS | Per-unit match |
| dbg_req_int | output | 1 | Request presented to the processor |
| dbg_ack | output | 1 | Core is in debug state |
| rx_empty | output | 1 | Debugger-to-core word empty |
| tx_empty | output | 1 | Core-to-debugger word empty |

## Verification
On every cycle the assertions check the following: a hit needs a valid access, and a trigger needs a hit. Acknowledge rises only from a pending request during a completing instruction and holds until exit. The global disable clears acknowledge. Status moves only at entry. A full mailbox stays full until it is drained. The masked compare over whole address, data and control sweeps can only be shown by the bench's scenarios. The same holds for the mode and qualify selection, the cause encoding in status, and the register truncation, because each needs expected values computed from the programmed patterns.

// File: rtl/dwc_pkg.sv
package dwc_pkg;
   // Per-unit register slot inside an 8-word window
   typedef enum logic [2:0] {
      F_AVAL = 3'd0,
      F_AMSK = 3'd1,
      F_DVAL = 3'd2,
      F_DMSK = 3'd3,
      F_CVAL = 3'd4,
      F_CMSK = 3'd5
   } field_e;

   // Global registers, offset from 8*N_UNITS
   localparam int G_CTRL = 0;
   localparam int G_STAT = 1;
   localparam int G_TX   = 2;
   localparam int G_RX   = 3;

   function automatic int slot_addr(input int unit, input int field);
      return unit * 8 + field;
   endfunction
endpackage

// File: rtl/dwc_compare.sv
module dwc_compare #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CTRL_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_fetch,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   input  logic [CTRL_W-1:0] bus_ctrl,
   input  logic [ADDR_W-1:0] a_val,
   input  logic [ADDR_W-1:0] a_msk,
   input  logic [DATA_W-1:0] d_val,
   input  logic [DATA_W-1:0] d_msk,
   input  logic [CTRL_W-1:0] c_val,
   input  logic [CTRL_W-1:0] c_msk,
   input  logic              en,
   input  logic              mode_data,
   input  logic              qual,
   input  logic              cond,
   output logic              hit,
   output logic              trig
);
   logic a_ok, d_ok, c_ok, kind_ok;

   assign a_ok    = ~|((bus_addr ^ a_val) & ~a_msk);
   assign d_ok    = ~|((bus_data ^ d_val) & ~d_msk);
   assign c_ok    = ~|((bus_ctrl ^ c_val) & ~c_msk);
   assign hit     = bus_valid & en & a_ok & d_ok & c_ok;
   assign kind_ok = mode_data ? ~bus_fetch : bus_fetch;
   assign trig    = hit & kind_ok & (~qual | cond);

   assert_hit_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> bus_valid);
   assert_trig_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      trig |-> (hit && (cond || !qual)));
endmodule

// File: rtl/dwc_comm.sv
module dwc_comm #(
   parameter int REG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_wr,
   input  logic [REG_W-1:0] tx_wdata,
   input  logic             tx_pop,
   input  logic             rx_push,
   input  logic [REG_W-1:0] rx_wdata,
   input  logic             rx_pop,
   output logic [REG_W-1:0] tx_data,
   output logic [REG_W-1:0] rx_data,
   output logic             tx_empty,
   output logic             rx_empty
);
   logic tx_full, rx_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_full <= 1'b0;
         rx_full <= 1'b0;
         tx_data <= '0;
         rx_data <= '0;
      end else begin
         if (tx_full) begin
            if (tx_pop) tx_full <= 1'b0;
         end else if (tx_wr) begin
            tx_full <= 1'b1;
            tx_data <= tx_wdata;
         end
         if (rx_full) begin
            if (rx_pop) rx_full <= 1'b0;
         end else if (rx_push) begin
            rx_full <= 1'b1;
            rx_data <= rx_wdata;
         end
      end
   end

   assign tx_empty = ~tx_full;
   assign rx_empty = ~rx_full;

   assert_tx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_full && !tx_pop) |=> (tx_full && $stable(tx_data)));
   assert_rx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && !rx_pop) |=> (rx_full && $stable(rx_data)));
endmodule

// File: rtl/dwc_seq.sv
module dwc_seq #(
   parameter int N_UNITS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dbg_en,
   input  logic [N_UNITS-1:0] trig,
   input  logic             bkpt_hit,
   input  logic             ext_req,
   input  logic             instr_done,
   input  logic             dbg_exit,
   output logic             dbg_ack,
   output logic             req_int,
   output logic [N_UNITS:0] status
);
   logic             pend;
   logic [N_UNITS:0] cause, fresh;

   assign fresh   = {bkpt_hit | ext_req, trig};
   assign req_int = dbg_en & ~dbg_ack & (pend | ext_req);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend    <= 1'b0;
         cause   <= '0;
         dbg_ack <= 1'b0;
         status  <= '0;
      end else if (!dbg_en) begin
         pend    <= 1'b0;
         cause   <= '0;
         dbg_ack <= 1'b0;
      end else if (dbg_ack) begin
         if (dbg_exit) dbg_ack <= 1'b0;
      end else if (pend && instr_done) begin
         dbg_ack <= 1'b1;
         status  <= cause;
         pend    <= 1'b0;
         cause   <= '0;
      end else if (|fresh) begin
         pend  <= 1'b1;
         cause <= cause | fresh;
      end
   end

   assert_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dbg_ack) |-> $past(pend && instr_done && dbg_en));
   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_ack && !dbg_exit && dbg_en) |=> dbg_ack);
   assert_disable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !dbg_en |=> (!dbg_ack && !pend));
   assert_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(pend && instr_done && dbg_en && !dbg_ack) |=> $stable(status));
endmodule

// File: rtl/dbg_watch_unit.sv
module dbg_watch_unit
   import dwc_pkg::*;
#(
   parameter int N_UNITS = 2,
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int CTRL_W  = 4,
   parameter int REG_W   = 32,
   localparam int GLB    = 8 * N_UNITS,
   localparam int REG_AW = $clog2(GLB) + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_valid,
   input  logic               bus_fetch,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_data,
   input  logic [CTRL_W-1:0]  bus_ctrl,
   input  logic [N_UNITS-1:0] ext_cond,
   input  logic               bkpt_in,
   input  logic               ext_dbg_req,
   input  logic               instr_done,
   input  logic               dbg_exit,
   input  logic               dbg_en,
   input  logic               reg_we,
   input  logic               reg_re,
   input  logic [REG_AW-1:0]  reg_addr,
   input  logic [REG_W-1:0]   reg_wdata,
   output logic [REG_W-1:0]   reg_rdata,
   input  logic               rx_push,
   input  logic [REG_W-1:0]   rx_data,
   input  logic               tx_pop,
   output logic [REG_W-1:0]   tx_data,
   output logic [N_UNITS-1:0] wp_hit,
   output logic               dbg_req_int,
   output logic               dbg_ack,
   output logic               rx_empty,
   output logic               tx_empty
);
   localparam int CR_W = 3 * N_UNITS;

   initial begin
      assert (N_UNITS >= 1 && N_UNITS <= 8) else $error("N_UNITS out of range");
      assert (ADDR_W <= REG_W && DATA_W <= REG_W && CTRL_W <= REG_W)
         else $error("field wider than register");
      assert (CR_W <= REG_W && N_UNITS + 1 <= REG_W) else $error("control too wide");
   end

   logic [ADDR_W-1:0]  a_val [N_UNITS];
   logic [ADDR_W-1:0]  a_msk [N_UNITS];
   logic [DATA_W-1:0]  d_val [N_UNITS];
   logic [DATA_W-1:0]  d_msk [N_UNITS];
   logic [CTRL_W-1:0]  c_val [N_UNITS];
   logic [CTRL_W-1:0]  c_msk [N_UNITS];
   logic [CR_W-1:0]    ctrl_q;
   logic [N_UNITS-1:0] trig;
   logic [N_UNITS:0]   status;
   logic [REG_W-1:0]   rx_word;

   function automatic logic at(input logic [REG_AW-1:0] a, input int slot);
      return a == REG_AW'(slot);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         for (int u = 0; u < N_UNITS; u++) begin
            a_val[u] <= '0; a_msk[u] <= '0;
            d_val[u] <= '0; d_msk[u] <= '0;
            c_val[u] <= '0; c_msk[u] <= '0;
         end
      end else if (reg_we) begin
         if (at(reg_addr, GLB + G_CTRL)) ctrl_q <= reg_wdata[CR_W-1:0];
         for (int u = 0; u < N_UNITS; u++) begin
            if (at(reg_addr, slot_addr(u, F_AVAL))) a_val[u] <= reg_wdata[ADDR_W-1:0];
            if (at(reg_addr, slot_addr(u, F_AMSK))) a_msk[u] <= reg_wdata[ADDR_W-1:0];
            if (at(reg_addr, slot_addr(u, F_DVAL))) d_val[u] <= reg_wdata[DATA_W-1:0];
            if (at(reg_addr, slot_addr(u, F_DMSK))) d_msk[u] <= reg_wdata[DATA_W-1:0];
            if (at(reg_addr, slot_addr(u, F_CVAL))) c_val[u] <= reg_wdata[CTRL_W-1:0];
            if (at(reg_addr, slot_addr(u, F_CMSK))) c_msk[u] <= reg_wdata[CTRL_W-1:0];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (at(reg_addr, GLB + G_CTRL)) reg_rdata = REG_W'(ctrl_q);
      if (at(reg_addr, GLB + G_STAT)) reg_rdata = REG_W'(status);
      if (at(reg_addr, GLB + G_RX))   reg_rdata = rx_word;
      for (int u = 0; u < N_UNITS; u++) begin
         if (at(reg_addr, slot_addr(u, F_AVAL))) reg_rdata = REG_W'(a_val[u]);
         if (at(reg_addr, slot_addr(u, F_AMSK))) reg_rdata = REG_W'(a_msk[u]);
         if (at(reg_addr, slot_addr(u, F_DVAL))) reg_rdata = REG_W'(d_val[u]);
         if (at(reg_addr, slot_addr(u, F_DMSK))) reg_rdata = REG_W'(d_msk[u]);
         if (at(reg_addr, slot_addr(u, F_CVAL))) reg_rdata = REG_W'(c_val[u]);
         if (at(reg_addr, slot_addr(u, F_CMSK))) reg_rdata = REG_W'(c_msk[u]);
      end
   end

   for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
      dwc_compare #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_cmp (
         .clk(clk), .rst_n(rst_n),
         .bus_valid(bus_valid), .bus_fetch(bus_fetch),
         .bus_addr(bus_addr), .bus_data(bus_data), .bus_ctrl(bus_ctrl),
         .a_val(a_val[g]), .a_msk(a_msk[g]),
         .d_val(d_val[g]), .d_msk(d_msk[g]),
         .c_val(c_val[g]), .c_msk(c_msk[g]),
         .en(ctrl_q[g]), .mode_data(ctrl_q[N_UNITS + g]),
         .qual(ctrl_q[2*N_UNITS + g]), .cond(ext_cond[g]),
         .hit(wp_hit[g]), .trig(trig[g])
      );
   end

   dwc_seq #(.N_UNITS(N_UNITS)) u_seq (
      .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .trig(trig),
      .bkpt_hit(bkpt_in & bus_valid), .ext_req(ext_dbg_req),
      .instr_done(instr_done), .dbg_exit(dbg_exit),
      .dbg_ack(dbg_ack), .req_int(dbg_req_int), .status(status)
   );

   dwc_comm #(.REG_W(REG_W)) u_comm (
      .clk(clk), .rst_n(rst_n),
      .tx_wr(reg_we && at(reg_addr, GLB + G_TX)), .tx_wdata(reg_wdata),
      .tx_pop(tx_pop), .rx_push(rx_push), .rx_wdata(rx_data),
      .rx_pop(reg_re && at(reg_addr, GLB + G_RX)),
      .tx_data(tx_data), .rx_data(rx_word),
      .tx_empty(tx_empty), .rx_empty(rx_empty)
   );

   assert_req_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_req_int |-> dbg_en);
   assert_ack_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_ack |-> !dbg_req_int);
endmodule

// File: tb/sim_dbg_watch_unit.sv
`timescale 1ns/1ps
module sim_dbg_watch_unit;
   localparam int N  = 2;
   localparam int AW = 6;
   localparam int DW = 4;
   localparam int CW = 2;
   localparam int RW = 8;
   localparam int G  = 8 * N;
   localparam int RA = $clog2(G) + 1;

   logic clk = 0, rst_n = 0;
   logic bus_valid = 0, bus_fetch = 0;
   logic [AW-1:0] bus_addr = 0;
   logic [DW-1:0] bus_data = 0;
   logic [CW-1:0] bus_ctrl = 0;
   logic [N-1:0]  ext_cond = 0;
   logic bkpt_in = 0, ext_dbg_req = 0, instr_done = 0, dbg_exit = 0, dbg_en = 0;
   logic reg_we = 0, reg_re = 0;
   logic [RA-1:0] reg_addr = 0;
   logic [RW-1:0] reg_wdata = 0, reg_rdata, rx_data = 0, tx_data;
   logic rx_push = 0, tx_pop = 0;
   logic [N-1:0] wp_hit;
   logic dbg_req_int, dbg_ack, rx_empty, tx_empty;

   int total = 0, bad = 0;

   always #10 clk = ~clk;

   dbg_watch_unit #(.N_UNITS(N), .ADDR_W(AW), .DATA_W(DW), .CTRL_W(CW), .REG_W(RW)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_fetch(bus_fetch),
      .bus_addr(bus_addr), .bus_data(bus_data), .bus_ctrl(bus_ctrl),
      .ext_cond(ext_cond), .bkpt_in(bkpt_in), .ext_dbg_req(ext_dbg_req),
      .instr_done(instr_done), .dbg_exit(dbg_exit), .dbg_en(dbg_en),
      .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .rx_push(rx_push), .rx_data(rx_data), .tx_pop(tx_pop),
      .tx_data(tx_data), .wp_hit(wp_hit), .dbg_req_int(dbg_req_int),
      .dbg_ack(dbg_ack), .rx_empty(rx_empty), .tx_empty(tx_empty));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input int a, input int d);
      reg_addr = RA'(a); reg_wdata = RW'(d); reg_we = 1;
      step();
      reg_we = 0;
   endtask

   task automatic rd(input int a, output logic [RW-1:0] v);
      reg_addr = RA'(a);
      #1 v = reg_rdata;
   endtask

   task automatic fill_unit(input int u, input int av, input int am,
                            input int dv, input int dm, input int cv, input int cm);
      wr(u*8+0, av); wr(u*8+1, am); wr(u*8+2, dv);
      wr(u*8+3, dm); wr(u*8+4, cv); wr(u*8+5, cm);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [RW-1:0] v;
      int fw [6];
      int masks [4];
      fw = '{6'h3F, 6'h3F, 4'hF, 4'hF, 2'h3, 2'h3};
      masks = '{0, 3, 'h30, 'h3F};

      repeat (2) @(negedge clk);
      // R1 reset state
      chk("R1 hit", wp_hit, 0);
      chk("R1 ack", dbg_ack, 0);
      chk("R1 req", dbg_req_int, 0);
      chk("R1 rx_empty", rx_empty, 1);
      chk("R1 tx_empty", tx_empty, 1);
      rst_n = 1;
      step();
      for (int a = 0; a < G + 4; a++) begin
         rd(a, v);
         chk("R1 reg", v, 0);
      end

      // R11 readback truncated to field width
      for (int u = 0; u < N; u++)
         for (int f = 0; f < 6; f++) begin
            wr(u*8+f, 'hFF);
            rd(u*8+f, v);
            chk("R11 field", v, fw[f]);
         end
      wr(G, 'hFF);
      rd(G, v);
      chk("R11 ctrl", v, 'h3F);
      wr(G+1, 'hFF);
      rd(G+1, v);
      chk("R8 status write ignored", v, 0);

      // R2 address sweep, unit0 enabled only, debug disabled
      wr(G, 'h01);
      bus_valid = 1;
      for (int mi = 0; mi < 4; mi++) begin
         fill_unit(0, 'h25, masks[mi], 0, 'hF, 0, 3);
         for (int a = 0; a < 64; a++) begin
            bus_addr = AW'(a);
            #1;
            chk("R2 addr", wp_hit, (((a ^ 'h25) & ~masks[mi] & 'h3F) == 0) ? 1 : 0);
         end
      end
      // R2 data sweep
      for (int m = 0; m < 16; m++) begin
         fill_unit(0, 0, 'h3F, 'hA, m, 0, 3);
         for (int d = 0; d < 16; d++) begin
            bus_data = DW'(d);
            #1;
            chk("R2 data", wp_hit, (((d ^ 'hA) & ~m & 'hF) == 0) ? 1 : 0);
         end
      end
      // R2 control field
      fill_unit(0, 0, 'h3F, 0, 'hF, 2, 0);
      for (int c = 0; c < 4; c++) begin
         bus_ctrl = CW'(c);
         #1;
         chk("R2 ctrl", wp_hit, (c == 2) ? 1 : 0);
      end
      bus_ctrl = 2;
      bus_valid = 0;
      #1 chk("R2 invalid", wp_hit, 0);
      step();
      // R7 hits while disabled raise nothing
      chk("R7 req", dbg_req_int, 0);
      chk("R7 ack", dbg_ack, 0);

      // R3 unit1 data watchpoint with qualify
      dbg_en = 1;
      fill_unit(1, 0, 'h3F, 0, 'hF, 0, 3);
      wr(G, 'h2A);
      bus_valid = 1; bus_fetch = 1;
      step();
      chk("R3 wrong kind", dbg_req_int, 0);
      bus_fetch = 0; ext_cond = 0;
      #1 chk("R2 unit1 hit", wp_hit, 2);
      step();
      chk("R3 qualifier low", dbg_req_int, 0);
      ext_cond = 2'b10;
      step();
      bus_valid = 0; ext_cond = 0;
      #1 chk("R6 pending", dbg_req_int, 1);
      chk("R6 no early ack", dbg_ack, 0);
      step();
      chk("R6 waits", dbg_ack, 0);
      instr_done = 1;
      step();
      instr_done = 0;
      chk("R6 ack", dbg_ack, 1);
      chk("R6 req drops", dbg_req_int, 0);
      rd(G+1, v);
      chk("R8 unit1 cause", v, 2);
      // R12 stimulus during debug is dropped
      bus_valid = 1; bkpt_in = 1; bus_fetch = 0; ext_cond = 2'b10;
      step();
      bus_valid = 0; bkpt_in = 0; ext_cond = 0;
      chk("R6 ack holds", dbg_ack, 1);
      dbg_exit = 1;
      step();
      dbg_exit = 0;
      chk("R6 exit", dbg_ack, 0);
      chk("R12 nothing pending", dbg_req_int, 0);

      // R4 bkpt_in needs bus_valid
      wr(G, 0);
      bkpt_in = 1;
      step();
      chk("R4 no valid", dbg_req_int, 0);
      bus_valid = 1;
      step();
      bkpt_in = 0; bus_valid = 0;
      #1 chk("R4 pending", dbg_req_int, 1);
      instr_done = 1;
      step();
      instr_done = 0;
      chk("R4 ack", dbg_ack, 1);
      rd(G+1, v);
      chk("R8 bkpt cause", v, 4);
      dbg_exit = 1; step(); dbg_exit = 0;

      // R5 external request
      ext_dbg_req = 1;
      #1 chk("R5 immediate", dbg_req_int, 1);
      step();
      ext_dbg_req = 0;
      #1 chk("R5 pending", dbg_req_int, 1);
      instr_done = 1; step(); instr_done = 0;
      chk("R5 ack", dbg_ack, 1);
      dbg_exit = 1; step(); dbg_exit = 0;

      // R7 disable
      ext_dbg_req = 1; dbg_en = 0;
      #1 chk("R7 gated", dbg_req_int, 0);
      step();
      ext_dbg_req = 0; dbg_en = 1;
      #1 chk("R7 no pending", dbg_req_int, 0);
      ext_dbg_req = 1; step(); ext_dbg_req = 0;
      instr_done = 1; step(); instr_done = 0;
      chk("R7 setup ack", dbg_ack, 1);
      dbg_en = 0;
      step();
      chk("R7 ack cleared", dbg_ack, 0);
      dbg_en = 1;

      // R3 unit0 fetch breakpoint
      fill_unit(0, 0, 'h3F, 0, 'hF, 0, 3);
      wr(G, 'h01);
      bus_valid = 1; bus_fetch = 0;
      step();
      chk("R3 fetch mode ignores data", dbg_req_int, 0);
      bus_fetch = 1;
      step();
      bus_valid = 0;
      instr_done = 1; step(); instr_done = 0;
      chk("R3 fetch ack", dbg_ack, 1);
      rd(G+1, v);
      chk("R8 unit0 cause", v, 1);
      dbg_exit = 1; step(); dbg_exit = 0;

      // R9 core to debugger
      wr(G+2, 'h5A);
      chk("R9 full", tx_empty, 0);
      chk("R9 data", tx_data, 'h5A);
      wr(G+2, 'h11);
      chk("R9 no overwrite", tx_data, 'h5A);
      tx_pop = 1; step(); tx_pop = 0;
      chk("R9 drained", tx_empty, 1);

      // R10 debugger to core
      rx_data = 'h3C; rx_push = 1; step();
      rx_data = 'h77; step(); rx_push = 0;
      chk("R10 full", rx_empty, 0);
      rd(G+3, v);
      chk("R10 data kept", v, 'h3C);
      chk("R10 plain read keeps", rx_empty, 0);
      reg_re = 1; step(); reg_re = 0;
      chk("R10 drained", rx_empty, 1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule